// File: doc/BRIEF.md
# Transmit Word Formatter

This block reshapes one 32-bit word, as software or a DMA engine writes it, into the bit arrangement that a serial transmitter loads in parallel into its shift buffer. Three transforms run in a fixed order. First, a per-bit mask keeps some input bits and replaces the rest with a pad value. The pad value can be a constant or a copy of one chosen input bit, which gives sign extension. Second, the word is rotated right by a multiple of four bits. Third, the whole word can be mirrored end to end.

Every accepted word carries its own format settings, because the configuration inputs are captured in the same cycle as the data. The result appears one clock later together with an output strobe. With mirroring off, bit 0 of the result is the first bit the transmitter sends. With mirroring on, bit 31 of the original arrangement goes out first.

Top module: `txfmt_pipe`

## Requirements
- R1: A data bit whose `fmt_mask` bit is 1 reaches the mask stage output unchanged.
- R2: A data bit whose `fmt_mask` bit is 0 is replaced by the pad value. `pad_sel` = 2'b00 gives 0, 2'b01 gives 1, and 2'b10 gives input bit `pad_pos` (a 5-bit index, 0 = LSB) of the original, unmasked word.
- R3: `pad_sel` = 2'b11 is reserved and pads with 0, exactly like 2'b00.
- R4: With `pad_sel` = 2'b10 and `pad_pos` pointing at the top kept bit, every masked-off bit carries that bit. For example, data 0x00008000 with mask 0x0000FFFF and index 15 gives 0xFFFF8000.
- R5: The rotate stage turns the word right by 4 × `rot_code` bits, for a shift of 0, 4, …, 28 bits. For example, 0x87654321 with code 7 gives 0x76543218.
- R6: Rotation is circular. No bit is lost, and bit 0 turned right by 4 lands in bit 28; 0x00000001 with code 1 gives 0x10000000.
- R7: With `rev_en` = 1, bit i of the rotated word goes to bit 31−i of the output. With `rev_en` = 0, the rotated word passes through unchanged.
- R8: The stages apply in the order mask/pad, rotate, reverse.
- R9: `out_vld` equals `in_vld` of the previous cycle, and `out_word` carries the result of the word accepted in that cycle.
- R10: When `in_vld` is 0, `out_word` holds its previous value, whatever the data and configuration inputs do.
- R11: A synchronous active-high `rst` clears `out_word` to 0 and `out_vld` to 0. It takes precedence over a word presented in the same cycle.
- R12: The configuration is sampled with each word, so back-to-back words with different settings are each formatted with their own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input word valid |
| in_word | input | 32 | Word in bus representation |
| fmt_mask | input | 32 | Per-bit keep mask (1 = keep) |
| pad_sel | input | 2 | Pad source: 00 zero, 01 one, 10 indexed bit, 11 reserved (zero) |
| pad_pos | input | 5 | Index of the input bit used as the pad value |
| rot_code | input | 3 | Right rotation in steps of 4 bits |
| rev_en | input | 1 | Mirror the word end to end |
| out_vld | output | 1 | Output word valid, one cycle after `in_vld` |
| out_word | output | 32 | Formatted word for the transmit buffer load |

## Verification
Two situations can arise in a single cycle. In the first, a new word and its strobe are presented while `rst` is high. The bench does this and judges that, one cycle later, the output is the cleared state and not the formatted word. In the second, the word that completes in a cycle meets a fresh word with different settings arriving in that same cycle. Back-to-back words with contrasting mask, pad, rotate and mirror settings provoke this, and each result is compared with an independent bit-by-bit model to show that no setting leaks from one word into the next.

// File: rtl/txfmt_pkg.sv
package txfmt_pkg;

  localparam int unsigned TXF_DW   = 32;
  localparam int unsigned TXF_RW   = 3;
  localparam int unsigned TXF_STEP = 4;

  typedef enum logic [1:0] {
    PAD_ZERO = 2'b00,
    PAD_ONE  = 2'b01,
    PAD_SRC  = 2'b10,
    PAD_RSVD = 2'b11
  } pad_sel_e;

  // Pad value for a given selector; the reserved code falls back to zero.
  function automatic logic pick_pad(input logic [1:0] sel, input logic src_bit);
    logic r;
    case (pad_sel_e'(sel))
      PAD_ONE: r = 1'b1;
      PAD_SRC: r = src_bit;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/txfmt_maskpad.sv
module txfmt_maskpad
  import txfmt_pkg::*;
#(
  parameter int unsigned DW = TXF_DW,
  localparam int unsigned IW = $clog2(DW)
) (
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] keep,
  input  logic [1:0]    sel,
  input  logic [IW-1:0] pos,
  output logic          pad_bit,
  output logic [DW-1:0] dout
);

  assign pad_bit = pick_pad(sel, din[pos]);

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign dout[i] = keep[i] ? din[i] : pad_bit;
  end

endmodule

// File: rtl/txfmt_rotate.sv
module txfmt_rotate
  import txfmt_pkg::*;
#(
  parameter int unsigned DW   = TXF_DW,
  parameter int unsigned RW   = TXF_RW,
  parameter int unsigned STEP = TXF_STEP
) (
  input  logic [DW-1:0] din,
  input  logic [RW-1:0] code,
  output logic [DW-1:0] dout
);

  localparam int unsigned NPOS = 1 << RW;

  logic [DW-1:0] cand [NPOS];

  // One candidate per code; each is a fixed wiring of the input word.
  for (genvar c = 0; c < NPOS; c++) begin : g_amt
    localparam int unsigned SH = (c * STEP) % DW;
    if (SH == 0) begin : g_none
      assign cand[c] = din;
    end else begin : g_turn
      assign cand[c] = {din[SH-1:0], din[DW-1:SH]};
    end
  end

  assign dout = cand[code];

endmodule

// File: rtl/txfmt_reverse.sv
module txfmt_reverse
  import txfmt_pkg::*;
#(
  parameter int unsigned DW = TXF_DW
) (
  input  logic [DW-1:0] din,
  input  logic          en,
  output logic [DW-1:0] dout
);

  logic [DW-1:0] mirrored;

  for (genvar i = 0; i < DW; i++) begin : g_mir
    assign mirrored[i] = din[DW-1-i];
  end

  assign dout = en ? mirrored : din;

endmodule

// File: rtl/txfmt_pipe.sv
module txfmt_pipe
  import txfmt_pkg::*;
#(
  parameter int unsigned DW   = TXF_DW,
  parameter int unsigned RW   = TXF_RW,
  parameter int unsigned STEP = TXF_STEP,
  localparam int unsigned IW  = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [31:0]   in_word,
  input  logic [31:0]   fmt_mask,
  input  logic [1:0]    pad_sel,
  input  logic [4:0]    pad_pos,
  input  logic [2:0]    rot_code,
  input  logic          rev_en,
  output logic          out_vld,
  output logic [31:0]   out_word
);

  // Named intermediate words, observed by the bound checker.
  logic          pad_bit;
  logic [DW-1:0] stage1_word;
  logic [DW-1:0] stage2_word;
  logic [DW-1:0] stage3_word;

  txfmt_maskpad #(.DW(DW)) u_mask (
    .din     (in_word[DW-1:0]),
    .keep    (fmt_mask[DW-1:0]),
    .sel     (pad_sel),
    .pos     (pad_pos[IW-1:0]),
    .pad_bit (pad_bit),
    .dout    (stage1_word)
  );

  txfmt_rotate #(.DW(DW), .RW(RW), .STEP(STEP)) u_rot (
    .din  (stage1_word),
    .code (rot_code[RW-1:0]),
    .dout (stage2_word)
  );

  txfmt_reverse #(.DW(DW)) u_rev (
    .din  (stage2_word),
    .en   (rev_en),
    .dout (stage3_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_word <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_word <= stage3_word;
    end
  end

endmodule

// File: rtl/txfmt_pipe_chk.sv
module txfmt_pipe_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_vld,
  input logic [31:0]   in_word,
  input logic [31:0]   fmt_mask,
  input logic          rev_en,
  input logic          pad_bit,
  input logic [DW-1:0] stage1_word,
  input logic [DW-1:0] stage2_word,
  input logic [DW-1:0] stage3_word,
  input logic          out_vld,
  input logic [31:0]   out_word
);

  // Set once a clock edge has passed with reset low.
  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  a_r1_kept_bits: assert property (@(posedge clk) disable iff (rst)
    ((stage1_word ^ in_word) & fmt_mask) == '0);

  a_r2_pad_fill: assert property (@(posedge clk) disable iff (rst)
    (stage1_word & ~fmt_mask) == ({DW{pad_bit}} & ~fmt_mask));

  a_r6_rotate_keeps_bits: assert property (@(posedge clk) disable iff (rst)
    $countones(stage2_word) == $countones(stage1_word));

  a_r7_reverse_keeps_bits: assert property (@(posedge clk) disable iff (rst)
    $countones(stage3_word) == $countones(stage2_word));

  a_r7_no_mirror_pass: assert property (@(posedge clk) disable iff (rst)
    !rev_en |-> stage3_word == stage2_word);

  a_r9_valid_latency: assert property (@(posedge clk) disable iff (rst)
    primed |-> out_vld == $past(in_vld));

  a_r9_word_loaded: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(in_vld)) |-> out_word == $past(stage3_word));

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (primed && !$past(in_vld)) |-> $stable(out_word));

  a_r11_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_vld && out_word == '0));

endmodule

bind txfmt_pipe txfmt_pipe_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_vld      (in_vld),
  .in_word     (in_word),
  .fmt_mask    (fmt_mask),
  .rev_en      (rev_en),
  .pad_bit     (pad_bit),
  .stage1_word (stage1_word),
  .stage2_word (stage2_word),
  .stage3_word (stage3_word),
  .out_vld     (out_vld),
  .out_word    (out_word)
);

// File: tb/sim_txfmt_pipe.sv
module sim_txfmt_pipe;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  typedef struct packed {
    logic [31:0] data;
    logic [31:0] mask;
    logic [1:0]  sel;
    logic [4:0]  pos;
    logic [2:0]  rot;
    logic        rev;
  } vec_t;

  localparam vec_t TBL [NVEC] = '{
    '{32'hA5A5_1234, 32'hFFFF_FFFF, 2'b00, 5'd0,  3'd0, 1'b0}, // R1 all kept
    '{32'h1234_5678, 32'h0000_FFFF, 2'b00, 5'd0,  3'd0, 1'b0}, // R2 zero pad
    '{32'h1234_5678, 32'h0000_FFFF, 2'b01, 5'd0,  3'd0, 1'b0}, // R2 one pad
    '{32'h0000_8000, 32'h0000_FFFF, 2'b10, 5'd15, 3'd0, 1'b0}, // R4 sign extend
    '{32'hFFFF_FFFF, 32'h00FF_00FF, 2'b11, 5'd3,  3'd0, 1'b0}, // R3 reserved code
    '{32'h0000_0001, 32'hFFFF_FFFF, 2'b00, 5'd0,  3'd1, 1'b0}, // R6 wrap
    '{32'h8765_4321, 32'hFFFF_FFFF, 2'b00, 5'd0,  3'd7, 1'b0}, // R5 largest turn
    '{32'h0000_0001, 32'hFFFF_FFFF, 2'b00, 5'd0,  3'd0, 1'b1}, // R7 mirror
    '{32'h0000_00F3, 32'h0000_00FF, 2'b10, 5'd7,  3'd2, 1'b1}, // R8 all stages
    '{32'h8000_0000, 32'h0000_0000, 2'b10, 5'd31, 3'd3, 1'b0}  // R2 indexed, all masked
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        in_vld;
  logic [31:0] in_word;
  logic [31:0] fmt_mask;
  logic [1:0]  pad_sel;
  logic [4:0]  pad_pos;
  logic [2:0]  rot_code;
  logic        rev_en;
  logic        out_vld;
  logic [31:0] out_word;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txfmt_pipe u0 (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_word  (in_word),
    .fmt_mask (fmt_mask),
    .pad_sel  (pad_sel),
    .pad_pos  (pad_pos),
    .rot_code (rot_code),
    .rev_en   (rev_en),
    .out_vld  (out_vld),
    .out_word (out_word)
  );

  // Independent model: trace each output bit back to its source position.
  function automatic logic [31:0] model(input vec_t v);
    logic [31:0] r;
    logic        pad;
    pad = (v.sel == 2'b01) ? 1'b1 : (v.sel == 2'b10) ? v.data[v.pos] : 1'b0;
    for (int k = 0; k < 32; k++) begin
      int j;
      int src;
      j   = v.rev ? (31 - k) : k;
      src = (j + 4 * int'(v.rot)) % 32;
      r[k] = v.mask[src] ? v.data[src] : pad;
    end
    return r;
  endfunction

  function automatic string tag_of(input int i);
    case (i)
      0:       return "R1";
      1, 2, 9: return "R2";
      3:       return "R4";
      4:       return "R3";
      5:       return "R6";
      6:       return "R5";
      7:       return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    in_vld   = vld;
    in_word  = v.data;
    fmt_mask = v.mask;
    pad_sel  = v.sel;
    pad_pos  = v.pos;
    rot_code = v.rot;
    rev_en   = v.rev;
  endtask

  initial begin
    vec_t a;
    vec_t b;
    rst = 1'b1;
    drive(TBL[0], 1'b0);
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", {31'd0, out_vld}, 32'd0);
    check("R11", out_word, 32'd0);
    rst = 1'b0;

    // Table walk: one word per two cycles, result checked one cycle later (R9)
    for (int i = 0; i < NVEC; i++) begin
      drive(TBL[i], 1'b1);
      @(negedge clk);
      check("R9", {31'd0, out_vld}, 32'd1);
      check(tag_of(i), out_word, model(TBL[i]));
      in_vld = 1'b0;
      @(negedge clk);
      check("R9", {31'd0, out_vld}, 32'd0);
    end

    // Hand-worked values
    drive(TBL[3], 1'b1); @(negedge clk); check("R4", out_word, 32'hFFFF_8000);
    drive(TBL[5], 1'b1); @(negedge clk); check("R6", out_word, 32'h1000_0000);
    drive(TBL[6], 1'b1); @(negedge clk); check("R5", out_word, 32'h7654_3218);
    drive(TBL[7], 1'b1); @(negedge clk); check("R7", out_word, 32'h8000_0000);

    // R10: inputs change without a strobe; output must hold
    drive(TBL[0], 1'b0);
    @(negedge clk);
    drive(TBL[9], 1'b0);
    @(negedge clk);
    check("R10", out_word, 32'h8000_0000);
    check("R10", {31'd0, out_vld}, 32'd0);

    // R12: back-to-back words with contrasting settings
    a = TBL[8];
    b = TBL[2];
    b.rot = 3'd5;
    drive(a, 1'b1);
    @(negedge clk);
    check("R12", out_word, model(a));
    drive(b, 1'b1);
    @(negedge clk);
    check("R12", out_word, model(b));
    check("R12", {31'd0, out_vld}, 32'd1);
    in_vld = 1'b0;
    @(negedge clk);

    // R11: reset and a valid word in the same cycle; reset wins
    rst = 1'b1;
    drive(TBL[6], 1'b1);
    @(negedge clk);
    rst = 1'b0;
    in_vld = 1'b0;
    check("R11", out_word, 32'd0);
    check("R11", {31'd0, out_vld}, 32'd0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule